// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block watches a bank of external interrupt lines and turns each request into a routing message for the processors of the system. Every line owns a 64-bit redirection entry that names the vector, the delivery kind, the target processors, the polarity flag, and the trigger style. It also carries a per-line mask. Software programs the entries through a two-register indirect window. An 8-bit selector sits at byte offset 0x00, and a 32-bit data port at byte offset 0x10 reaches the register that the selector names.

A line can be edge triggered or level triggered. An edge line remembers each rising edge as a pending request until a message for it leaves the block. A level line is pending for as long as it is held high. The destination byte is expanded into a per-processor bitmask. In physical mode the byte is a processor ID. In logical mode it is matched against a table of per-processor logical bytes, which is loaded through a small side port. For the lowest-priority delivery kind, only one target survives.

Messages leave through a valid/ready handshake, one message per accepted transfer. When several lines are eligible, the lowest-numbered line goes first.

Top module: `irq_redirect`

## Requirements
- R1: After reset the selector reads 0, the ID register reads 0, and every entry reads 0x00010000 in its low half and 0 in its high half (mask set, nothing else). No message is valid.
- R2: A write to byte offset 0x00 loads the selector, which reads back in bits 7:0 at that offset. Byte offset 0x10 is the data window. Selector 0x10+2n reaches bits 31:0 of line n's entry and 0x11+2n reaches bits 63:32. A selector that names nothing reads 0 and ignores writes.
- R3: Selector 0x00 holds the 8-bit ID in bits 31:24. Selector 0x01 reads 0x00170011 (0x11 in bits 7:0, line count minus one in bits 23:16). Selector 0x02 reads 0. Writes to selectors 0x01 and 0x02 change nothing.
- R4: Entry fields are: vector in bits 7:0, delivery kind in bits 10:8, destination mode in bit 11 (1 = logical), polarity in bit 13, trigger in bit 15 (1 = level), mask in bit 16, and destination byte in bits 63:56. The vector, delivery kind, polarity and trigger are copied unchanged into the message.
- R5: An edge line's rising edge makes it pending. Issuing its message clears the pending bit, so one edge gives exactly one message. An edge that arrives while the line is masked is delivered once the mask is cleared.
- R6: A high, unmasked level line issues one message. It is not issued again while it stays high, until its own entry is written or the line falls and rises again. A level line that falls before it is unmasked issues nothing.
- R7: In physical mode, destination 0xFF selects all processors, a destination below the processor count selects only that processor, and any other value gives an empty mask.
- R8: In logical mode, processor c is selected when its logical byte ANDed with the destination byte is nonzero.
- R9: With delivery kind 1 (lowest priority), only the lowest-numbered bit of the computed mask is kept.
- R10: When several lines are eligible at once, the lowest-numbered line is issued first.
- R11: A valid message holds all its fields stable until it is accepted (valid and ready high at a clock edge). Each accepted transfer carries exactly one message.
- R12: A masked line issues no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Interrupt request lines, synchronous to clk |
| reg_addr | input | 8 | Register byte offset (0x00 selector, 0x10 window) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lmap_we | input | 1 | Logical table write strobe |
| lmap_idx | input | 3 | Processor index of the logical table write |
| lmap_val | input | 8 | Logical byte for that processor |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Target processor bitmask |
| msg_mode | output | 3 | Delivery kind |
| msg_vector | output | 8 | Vector |
| msg_pol | output | 1 | Polarity flag |
| msg_trig | output | 1 | Trigger style (1 = level) |

## Verification
The hardest case to reach from the ports is a level line that is still high after its message was taken. Here the block must stay silent until the line's own entry is rewritten or the line toggles. The stimulus holds such a line high across idle cycles and checks for silence. It then rewrites the same entry value, and later drops and raises the line, expecting exactly one new message each time. A second awkward case is several lines becoming pending in the same cycle while the consumer stalls. Two edges are pulsed together with ready held low, so that the priority order and field stability under backpressure can be observed.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;

    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
    localparam logic [7:0]  SEL_ID    = 8'h00;
    localparam logic [7:0]  SEL_VER   = 8'h01;
    localparam logic [7:0]  SEL_ARB   = 8'h02;
    localparam logic [7:0]  SEL_TBL   = 8'h10;
    localparam logic [7:0]  OFS_SEL   = 8'h00;
    localparam logic [7:0]  OFS_WIN   = 8'h10;
    localparam logic [7:0]  VERSION   = 8'h11;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTERN = 3'd7
    } dlv_mode_e;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd_hi;
        logic        mask;
        logic        trig;
        logic        rsvd14;
        logic        pol;
        logic        rsvd12;
        logic        dmode;
        dlv_mode_e   mode;
        logic [7:0]  vector;
    } rte_t;

endpackage

// File: rtl/irq_rte_regs.sv
module irq_rte_regs
    import irq_redirect_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              reg_addr,
    input  logic                    reg_we,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output rte_t [NPINS-1:0]        entry_o,
    output logic [NPINS-1:0]        wr_pin_o
);
    localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [6:0] NPINS7 = 7'(NPINS);
    localparam logic [7:0] TOP_LINE = 8'(NPINS - 1);

    logic [7:0]  sel_q;
    logic [7:0]  id_q;
    logic [63:0] raw_q [NPINS];

    logic [7:0]    off;
    logic          in_tbl;
    logic [PW-1:0] line;
    logic          win_hit;
    logic          wr_win;

    assign off     = sel_q - SEL_TBL;
    assign in_tbl  = (sel_q >= SEL_TBL) && (off[7:1] < NPINS7);
    assign line    = off[PW:1];
    assign win_hit = (reg_addr == OFS_WIN);
    assign wr_win  = reg_we && win_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (reg_we && reg_addr == OFS_SEL) begin
            sel_q <= reg_wdata[7:0];
        end else if (wr_win && sel_q == SEL_ID) begin
            id_q <= reg_wdata[31:24];
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[p] <= ENTRY_RST;
            end else if (wr_pin_o[p]) begin
                if (off[0]) raw_q[p][63:32] <= reg_wdata;
                else        raw_q[p][31:0]  <= reg_wdata;
            end
        end
        assign wr_pin_o[p] = wr_win && in_tbl && (line == PW'(p));
        assign entry_o[p]  = rte_t'(raw_q[p]);
    end

    logic [31:0] win_val;
    always_comb begin
        win_val = '0;
        case (sel_q)
            SEL_ID:  win_val = {id_q, 24'h0};
            SEL_VER: win_val = {8'h00, TOP_LINE, 8'h00, VERSION};
            SEL_ARB: win_val = '0;
            default: begin
                if (in_tbl) win_val = off[0] ? raw_q[line][63:32] : raw_q[line][31:0];
            end
        endcase
    end

    always_comb begin
        if (reg_addr == OFS_SEL)  reg_rdata = {24'h0, sel_q};
        else if (win_hit)         reg_rdata = win_val;
        else                      reg_rdata = '0;
    end

    AST_RO_SELECTORS: assert property (@(posedge clk) disable iff (rst)
        (wr_win && (sel_q == SEL_VER || sel_q == SEL_ARB)) |=> $stable(id_q)); // R3

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_win && !in_tbl) |-> (wr_pin_o == '0)); // R2

endmodule

// File: rtl/irq_pend_pick.sv
module irq_pend_pick #(
    parameter int NPINS = 24,
    localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [NPINS-1:0]  lvl_i,
    input  logic [NPINS-1:0]  msk_i,
    input  logic [NPINS-1:0]  wr_pin_i,
    input  logic              take_i,
    output logic              any_o,
    output logic [PW-1:0]     idx_o
);
    logic [NPINS-1:0] pin_q;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] fired_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] elig;
    logic [NPINS-1:0] gnt;

    assign rise = pin_i & ~pin_q;
    assign elig = pend_q & ~msk_i & ~fired_q;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_o = 1'b1;
                idx_o = PW'(i);
            end
        end
    end

    assign gnt = take_i ? (NPINS'(1) << idx_o) : '0;

    for (genvar p = 0; p < NPINS; p++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q[p]   <= 1'b0;
                pend_q[p]  <= 1'b0;
                fired_q[p] <= 1'b0;
            end else begin
                pin_q[p] <= pin_i[p];
                if (lvl_i[p]) begin
                    pend_q[p]  <= pin_i[p];
                    fired_q[p] <= (fired_q[p] | gnt[p]) & pin_i[p] & ~wr_pin_i[p];
                end else begin
                    pend_q[p]  <= (pend_q[p] & ~gnt[p]) | rise[p];
                    fired_q[p] <= 1'b0;
                end
            end
        end
    end

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (take_i && !lvl_i[idx_o] && !rise[idx_o]) |=> !pend_q[$past(idx_o)]); // R5

    AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (rst)
        (take_i && lvl_i[idx_o] && pin_i[idx_o] && !wr_pin_i[idx_o]) |=> !elig[$past(idx_o)]); // R6

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        take_i |-> ((elig & ((NPINS'(1) << idx_o) - NPINS'(1))) == '0)); // R10

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_redirect_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  rte_t                   entry_i,
    input  logic [NCPU-1:0][7:0]   lmap_i,
    output logic [NCPU-1:0]        mask_o
);
    logic [NCPU-1:0] raw_mask;

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            if (entry_i.dmode)
                raw_mask[c] = |(lmap_i[c] & entry_i.dest);
            else
                raw_mask[c] = (entry_i.dest == 8'hFF) || (entry_i.dest == 8'(c));
        end
    end

    assign mask_o = (entry_i.mode == DM_LOWEST) ? (raw_mask & (~raw_mask + NCPU'(1))) : raw_mask;

    AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (entry_i.mode == DM_LOWEST) |-> $onehot0(mask_o)); // R9

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (rst)
        (!entry_i.dmode && entry_i.dest == 8'hFF && entry_i.mode != DM_LOWEST) |-> (&mask_o)); // R7

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
    import irq_redirect_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int NCPU  = 8,
    localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  irq_in,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lmap_we,
    input  logic [CW-1:0]     lmap_idx,
    input  logic [7:0]        lmap_val,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [NCPU-1:0]   msg_dest,
    output logic [2:0]        msg_mode,
    output logic [7:0]        msg_vector,
    output logic              msg_pol,
    output logic              msg_trig
);
    rte_t [NPINS-1:0]     entries;
    logic [NPINS-1:0]     wr_pin;
    logic [NPINS-1:0]     lvl;
    logic [NPINS-1:0]     msk;
    logic                 any;
    logic [PW-1:0]        pick;
    logic                 take;
    rte_t                 cur;
    logic [NCPU-1:0]      route_mask;
    logic [NCPU-1:0][7:0] lmap_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_flags
        assign lvl[p] = entries[p].trig;
        assign msk[p] = entries[p].mask;
    end

    irq_rte_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .entry_o   (entries),
        .wr_pin_o  (wr_pin)
    );

    irq_pend_pick #(.NPINS(NPINS)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (irq_in),
        .lvl_i    (lvl),
        .msk_i    (msk),
        .wr_pin_i (wr_pin),
        .take_i   (take),
        .any_o    (any),
        .idx_o    (pick)
    );

    assign cur  = entries[pick];
    assign take = any && !msg_valid;

    irq_route #(.NCPU(NCPU)) u_route (
        .clk     (clk),
        .rst     (rst),
        .entry_i (cur),
        .lmap_i  (lmap_q),
        .mask_o  (route_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lmap_q <= '0;
        end else if (lmap_we) begin
            lmap_q[lmap_idx] <= lmap_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid  <= 1'b0;
            msg_dest   <= '0;
            msg_mode   <= '0;
            msg_vector <= '0;
            msg_pol    <= 1'b0;
            msg_trig   <= 1'b0;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end else if (take) begin
            msg_valid  <= 1'b1;
            msg_dest   <= route_mask;
            msg_mode   <= cur.mode;
            msg_vector <= cur.vector;
            msg_pol    <= cur.pol;
            msg_trig   <= cur.trig;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                       && $stable(msg_mode))); // R11

    AST_NO_MASKED: assert property (@(posedge clk) disable iff (rst)
        take |-> !cur.mask); // R12

    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid); // R11

endmodule

// File: tb/irq_redirect_tb.sv
module irq_redirect_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lmap_we = 1'b0;
    logic [2:0]  lmap_idx = '0;
    logic [7:0]  lmap_val = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic [2:0]  msg_mode;
    logic [7:0]  msg_vector;
    logic        msg_pol;
    logic        msg_trig;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_redirect u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lmap_we(lmap_we), .lmap_idx(lmap_idx), .lmap_val(lmap_val),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_pol(msg_pol), .msg_trig(msg_trig)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic win_write(input logic [7:0] s, input logic [31:0] d);
        reg_write(8'h00, {24'h0, s});
        reg_write(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        reg_write(8'h00, {24'h0, s});
        reg_addr = 8'h10;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                          input bit dm, input bit pol, input bit trig, input bit msk);
        return {15'h0, msk, trig, 1'b0, pol, 1'b0, dm, mode, vec};
    endfunction

    // write high half first so the entry stays masked until the low half lands
    task automatic prog(input int pin, input logic [31:0] lo, input logic [7:0] dest);
        win_write(8'(8'h11 + 2 * pin), {dest, 24'h0});
        win_write(8'(8'h10 + 2 * pin), lo);
    endtask

    task automatic pulse(input int pin);
        @(negedge clk); irq_in[pin] = 1'b1;
        @(negedge clk); irq_in[pin] = 1'b0;
    endtask

    task automatic expect_msg(input string req, input logic [7:0] dest, input logic [2:0] mode,
                              input logic [7:0] vec, input bit pol, input bit trig, input int hold);
        logic [20:0] exp, act;
        bit seen = 1'b0;
        exp = {dest, mode, vec, pol, trig};
        for (int i = 0; i < 30 && !seen; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        act = {msg_dest, msg_mode, msg_vector, msg_pol, msg_trig};
        check(seen && act == exp, req, {11'h0, act}, {11'h0, exp});
        if (hold > 0) begin
            bit steady = 1'b1;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                if (!msg_valid || {msg_dest, msg_mode, msg_vector, msg_pol, msg_trig} != exp) steady = 1'b0;
            end
            check(steady, "R11 hold under stall", {11'h0, msg_dest, msg_mode, msg_vector, msg_pol, msg_trig}, {11'h0, exp});
        end
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(input string req, input int n);
        bit quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) quiet = 1'b0;
        end
        check(quiet, req, {31'h0, !quiet}, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_addr = 8'h00;
        #1 check(reg_rdata == 32'h0, "R1 selector reset", reg_rdata, 32'h0);
        check(msg_valid == 1'b0, "R1 no message", {31'h0, msg_valid}, 32'h0);
        win_read(8'h00, d); check(d == 32'h0, "R1 id reset", d, 32'h0);
        win_read(8'h10, d); check(d == 32'h0001_0000, "R1 line0 low", d, 32'h0001_0000);
        win_read(8'h3F, d); check(d == 32'h0, "R1 line23 high", d, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        win_write(8'h00, 32'hAB12_3456);
        win_read(8'h00, d); check(d == 32'hAB00_0000, "R3 id field", d, 32'hAB00_0000);
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, d); check(d == 32'h0017_0011, "R3 version", d, 32'h0017_0011);
        win_write(8'h02, 32'h1234_5678);
        win_read(8'h02, d); check(d == 32'h0, "R3 selector 2 zero", d, 32'h0);
        win_read(8'h00, d); check(d == 32'hAB00_0000, "R3 id kept", d, 32'hAB00_0000);
        win_write(8'h1B, 32'hC3A5_5A3C);
        win_read(8'h1B, d); check(d == 32'hC3A5_5A3C, "R2 line5 high", d, 32'hC3A5_5A3C);
        win_read(8'h1A, d); check(d == 32'h0001_0000, "R2 line5 low untouched", d, 32'h0001_0000);
        win_write(8'h40, 32'hDEAD_BEEF);
        win_read(8'h40, d); check(d == 32'h0, "R2 unmapped selector", d, 32'h0);
        reg_write(8'h00, 32'h0000_001B);
        #1 check(reg_rdata == 32'h1B, "R2 selector readback", reg_rdata, 32'h1B);
    endtask

    task automatic t_edge();
        prog(3, mk_lo(8'h33, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0), 8'h02);
        expect_none("R5 no spurious", 5);
        pulse(3);
        expect_msg("R4 R5 edge fields", 8'h04, 3'd4, 8'h33, 1'b1, 1'b0, 0);
        expect_none("R5 single message per edge", 10);
    endtask

    task automatic t_masked();
        prog(4, mk_lo(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1), 8'h01);
        pulse(4);
        expect_none("R12 masked edge silent", 10);
        win_write(8'h18, mk_lo(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        expect_msg("R5 held edge after unmask", 8'h02, 3'd0, 8'h44, 1'b0, 1'b0, 0);
        expect_none("R5 held edge once", 8);
    endtask

    task automatic t_level();
        prog(6, mk_lo(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), 8'hFF);
        @(negedge clk); irq_in[6] = 1'b1;
        expect_msg("R6 R7 level broadcast", 8'hFF, 3'd0, 8'h66, 1'b0, 1'b1, 0);
        expect_none("R6 no repeat while high", 12);
        win_write(8'h1C, mk_lo(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        expect_msg("R6 reissue after entry write", 8'hFF, 3'd0, 8'h66, 1'b0, 1'b1, 0);
        expect_none("R6 quiet again", 6);
        @(negedge clk); irq_in[6] = 1'b0;
        expect_none("R6 low line quiet", 4);
        @(negedge clk); irq_in[6] = 1'b1;
        expect_msg("R6 reissue after toggle", 8'hFF, 3'd0, 8'h66, 1'b0, 1'b1, 0);
        @(negedge clk); irq_in[6] = 1'b0;
        win_write(8'h1C, mk_lo(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        @(negedge clk); irq_in[6] = 1'b1;
        @(negedge clk); irq_in[6] = 1'b0;
        win_write(8'h1C, mk_lo(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        expect_none("R6 dropped level while masked", 8);
    endtask

    task automatic set_lmap(input logic [2:0] c, input logic [7:0] v);
        @(negedge clk); lmap_we = 1'b1; lmap_idx = c; lmap_val = v;
        @(negedge clk); lmap_we = 1'b0;
    endtask

    task automatic t_route();
        set_lmap(3'd0, 8'h01);
        set_lmap(3'd1, 8'h03);
        set_lmap(3'd5, 8'h80);
        prog(7, mk_lo(8'h77, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0), 8'h02);
        pulse(7);
        expect_msg("R8 logical single", 8'h02, 3'd0, 8'h77, 1'b0, 1'b0, 0);
        prog(7, mk_lo(8'h78, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0), 8'h81);
        pulse(7);
        expect_msg("R8 logical multi", 8'h23, 3'd0, 8'h78, 1'b0, 1'b0, 0);
        prog(7, mk_lo(8'h79, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0), 8'hA0);
        pulse(7);
        expect_msg("R9 lowest of logical", 8'h20, 3'd1, 8'h79, 1'b0, 1'b0, 0);
        prog(7, mk_lo(8'h7A, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0), 8'hFF);
        pulse(7);
        expect_msg("R9 lowest of broadcast", 8'h01, 3'd1, 8'h7A, 1'b0, 1'b0, 0);
        prog(7, mk_lo(8'h7B, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h09);
        pulse(7);
        expect_msg("R7 out of range id", 8'h00, 3'd0, 8'h7B, 1'b0, 1'b0, 0);
    endtask

    task automatic t_priority();
        prog(2, mk_lo(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h01);
        prog(10, mk_lo(8'hAA, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h03);
        @(negedge clk); irq_in[2] = 1'b1; irq_in[10] = 1'b1;
        @(negedge clk); irq_in[2] = 1'b0; irq_in[10] = 1'b0;
        expect_msg("R10 lowest line first", 8'h02, 3'd0, 8'h22, 1'b0, 1'b0, 6);
        expect_msg("R10 R11 second line next", 8'h08, 3'd0, 8'hAA, 1'b0, 1'b0, 0);
        expect_none("R11 no extra message", 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_edge();
        t_masked();
        t_level();
        t_route();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule